// File: doc/BRIEF.md
# Warp Memory Request Coalescer

The block takes one warp-wide load request: a flat vector of per-lane byte addresses and a per-lane active mask. It merges the active lanes into the fewest memory transactions. Each transaction covers one 128-byte line and carries a 4-bit mask of the 32-byte sectors that the request touches inside that line. Transactions go out on a valid/ready port in ascending line order. When the last one has been accepted, the block pulses a done flag. The pulse carries the transaction count, the number of sectors moved and the bandwidth efficiency of the request.

Every lane reads one 4-byte word. The memory side returns each line with its line address. The block steers the word at each lane's in-line offset into that lane's result slot, so a single line response serves every lane that falls in it. Lanes that are inactive receive zero.

Top module: `coal_warp`

## Requirements
- R1: After reset, req_ready_o is 1, txn_valid_o is 0, done_o is 0 and every lane result is zero.
- R2: A request is taken only while req_ready_o is 1. req_ready_o stays 0 from the cycle after acceptance until done_o is raised, and it is 1 again in the cycle that done_o is high.
- R3: Every transaction's txn_line_o equals address bits [ADDR_W-1:7] of at least one active lane. Bit k of txn_sect_o is set exactly when some active lane in that line has address bits [6:5] equal to k, so the mask is never zero.
- R4: Transactions are issued in strictly ascending line order, and each distinct line touched by an active lane is issued exactly once.
- R5: While txn_valid_o is 1 and txn_ready_i is 0, the next cycle presents the same line and sector mask with txn_valid_o still 1.
- R6: Lanes whose mask bit is clear contribute no sectors. A request with an all-zero mask issues no transaction and still produces done_o, with all counts zero.
- R7: done_o is a single-cycle pulse in the cycle after the last transaction is accepted. done_txns_o gives the number of transactions and done_sects_o gives the total number of set sector bits.
- R8: done_eff_o equals min(100, floor(100*A/(8*S))), where A is the number of active lanes and S is done_sects_o. It is 0 when S is 0. For example, consecutive words give 100, a stride of 2 words gives 50, 16-byte records give 25 and 32 scattered lines give 12.
- R9: A response on rsp_valid_i whose rsp_line_i matches an active lane's line loads that lane's result with bits [32w+31:32w] of rsp_data_i, where w is address bits [6:2]. Results are cleared when a new request is taken.
- R10: 32 active lanes reading consecutive words of one aligned line yield exactly one transaction with sector mask 4'b1111. Lanes that share an address merge into one sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_addr_i | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_mask_i | input | LANES | Per-lane active mask |
| txn_valid_o | output | 1 | Transaction present |
| txn_ready_i | input | 1 | Memory accepts the transaction |
| txn_line_o | output | ADDR_W-7 | Line address (byte address bits [ADDR_W-1:7]) |
| txn_sect_o | output | 4 | Sectors needed within the line |
| rsp_valid_i | input | 1 | Line response present |
| rsp_line_i | input | ADDR_W-7 | Line address of the response |
| rsp_data_i | input | 1024 | Line data, word w at bits [32w+31:32w] |
| lane_data_o | output | LANES*32 | Per-lane results, lane i at bits [i*32 +: 32] |
| done_o | output | 1 | One-cycle completion pulse |
| done_txns_o | output | $clog2(LANES+1) | Transactions issued for the request |
| done_sects_o | output | $clog2(LANES+1) | Sectors moved for the request |
| done_eff_o | output | 8 | Efficiency in percent |

## Verification
The bench builds the block with its default parameters: 32 lanes and 32-bit addresses. That size makes the full-width cases reachable. These include a 32-line scatter that exercises the whole ascending-order pick chain, 16-byte records that fill four lines, and a full-warp broadcast where every lane lands in one sector, which checks the 100 percent clamp. Scatter addresses are presented in descending order under a stalling ready pattern, so both the reordering and the hold behaviour are observable at the ports.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned SECT_BYTES = 32;
  localparam int unsigned LINE_BYTES = 128;
  localparam int unsigned SECTS      = LINE_BYTES / SECT_BYTES;
  localparam int unsigned WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int unsigned WORD_BITS  = WORD_BYTES * 8;
  localparam int unsigned LINE_BITS  = LINE_BYTES * 8;
  localparam int unsigned LINE_OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned SECT_OFF_W = $clog2(SECT_BYTES);
  localparam int unsigned WORD_OFF_W = $clog2(WORD_BYTES);

  typedef enum logic [0:0] {ST_IDLE, ST_BUSY} coal_st_e;
endpackage

// File: rtl/coal_line_pick.sv
module coal_line_pick
  import coal_pkg::*;
#(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LINE_W = ADDR_W - LINE_OFF_W
) (
  input  logic [LANES-1:0][ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]             pend_i,
  output logic                         any_o,
  output logic [LINE_W-1:0]            line_o,
  output logic [SECTS-1:0]             sect_o,
  output logic [LANES-1:0]             hit_o
);
  // lowest pending line, then every pending lane that shares it
  always_comb begin
    any_o  = 1'b0;
    line_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend_i[i] && (!any_o || addr_i[i][ADDR_W-1:LINE_OFF_W] < line_o)) begin
        line_o = addr_i[i][ADDR_W-1:LINE_OFF_W];
        any_o  = 1'b1;
      end
    end
    hit_o  = '0;
    sect_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend_i[i] && addr_i[i][ADDR_W-1:LINE_OFF_W] == line_o) begin
        hit_o[i] = 1'b1;
        sect_o[addr_i[i][LINE_OFF_W-1:SECT_OFF_W]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_lane_route.sv
module coal_lane_route
  import coal_pkg::*;
#(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LINE_W = ADDR_W - LINE_OFF_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic [LANES-1:0]             act_i,
  input  logic [LANES-1:0][ADDR_W-1:0] addr_i,
  input  logic                         rsp_valid_i,
  input  logic [LINE_W-1:0]            rsp_line_i,
  input  logic [LINE_BITS-1:0]         rsp_data_i,
  output logic [LANES*WORD_BITS-1:0]   lane_data_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_BITS-1:0]                   data_q;
    logic [LINE_OFF_W-WORD_OFF_W-1:0]       widx;
    logic                                   take;

    assign widx = addr_i[g][LINE_OFF_W-1:WORD_OFF_W];
    assign take = rsp_valid_i && act_i[g] &&
                  (addr_i[g][ADDR_W-1:LINE_OFF_W] == rsp_line_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    data_q <= '0;
      else if (clr_i) data_q <= '0;
      else if (take)  data_q <= rsp_data_i[widx*WORD_BITS +: WORD_BITS];
    end

    assign lane_data_o[g*WORD_BITS +: WORD_BITS] = data_q;
  end
endmodule

// File: rtl/coal_eff.sv
module coal_eff #(
  parameter int unsigned CNT_W = 6,
  localparam int unsigned NUM_W = CNT_W + 7
) (
  input  logic [CNT_W-1:0] act_i,
  input  logic [CNT_W-1:0] sect_i,
  output logic [7:0]       eff_o
);
  logic [NUM_W-1:0] num, den, quo;

  always_comb begin
    num = NUM_W'(act_i) * NUM_W'(100);
    den = NUM_W'(sect_i) << 3;
    quo = (den == '0) ? '0 : num / den;
    eff_o = (quo > NUM_W'(100)) ? 8'd100 : quo[7:0];
  end
endmodule

// File: rtl/coal_warp.sv
module coal_warp
  import coal_pkg::*;
#(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LINE_W = ADDR_W - LINE_OFF_W,
  localparam int unsigned CNT_W  = $clog2(LANES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [LANES*ADDR_W-1:0]    req_addr_i,
  input  logic [LANES-1:0]           req_mask_i,
  output logic                       txn_valid_o,
  input  logic                       txn_ready_i,
  output logic [LINE_W-1:0]          txn_line_o,
  output logic [SECTS-1:0]           txn_sect_o,
  input  logic                       rsp_valid_i,
  input  logic [LINE_W-1:0]          rsp_line_i,
  input  logic [LINE_BITS-1:0]       rsp_data_i,
  output logic [LANES*WORD_BITS-1:0] lane_data_o,
  output logic                       done_o,
  output logic [CNT_W-1:0]           done_txns_o,
  output logic [CNT_W-1:0]           done_sects_o,
  output logic [7:0]                 done_eff_o
);
  coal_st_e                   st_q;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0]           act_q, pend_q, hit, pend_nxt;
  logic [CNT_W-1:0]           txn_cnt_q, sect_cnt_q, act_cnt_q;
  logic                       done_q, pick_any, take_req, fire;
  logic [LINE_W-1:0]          pick_line;
  logic [SECTS-1:0]           pick_sect;

  coal_line_pick #(.LANES(LANES), .ADDR_W(ADDR_W)) u_pick (
    .addr_i (addr_q),
    .pend_i (pend_q),
    .any_o  (pick_any),
    .line_o (pick_line),
    .sect_o (pick_sect),
    .hit_o  (hit)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign take_req    = req_ready_o && req_valid_i;
  assign txn_valid_o = (st_q == ST_BUSY) && pick_any;
  assign fire        = txn_valid_o && txn_ready_i;
  assign txn_line_o  = pick_line;
  assign txn_sect_o  = pick_sect;
  assign pend_nxt    = pend_q & ~hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      act_q      <= '0;
      pend_q     <= '0;
      txn_cnt_q  <= '0;
      sect_cnt_q <= '0;
      act_cnt_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take_req) begin
        st_q       <= ST_BUSY;
        addr_q     <= req_addr_i;
        act_q      <= req_mask_i;
        pend_q     <= req_mask_i;
        txn_cnt_q  <= '0;
        sect_cnt_q <= '0;
        act_cnt_q  <= CNT_W'($countones(req_mask_i));
      end else if (st_q == ST_BUSY) begin
        if (fire) begin
          pend_q     <= pend_nxt;
          txn_cnt_q  <= txn_cnt_q + 1'b1;
          sect_cnt_q <= sect_cnt_q + CNT_W'($countones(pick_sect));
          if (pend_nxt == '0) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end else if (!pick_any) begin
          done_q <= 1'b1;  // empty mask
          st_q   <= ST_IDLE;
        end
      end
    end
  end

  coal_lane_route #(.LANES(LANES), .ADDR_W(ADDR_W)) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (take_req),
    .act_i       (act_q),
    .addr_i      (addr_q),
    .rsp_valid_i (rsp_valid_i),
    .rsp_line_i  (rsp_line_i),
    .rsp_data_i  (rsp_data_i),
    .lane_data_o (lane_data_o)
  );

  coal_eff #(.CNT_W(CNT_W)) u_eff (
    .act_i  (act_cnt_q),
    .sect_i (sect_cnt_q),
    .eff_o  (done_eff_o)
  );

  assign done_o       = done_q;
  assign done_txns_o  = txn_cnt_q;
  assign done_sects_o = sect_cnt_q;
endmodule

// File: rtl/coal_warp_chk.sv
module coal_warp_chk
  import coal_pkg::*;
#(
  parameter int unsigned LINE_W = 25,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              txn_valid_o,
  input logic              txn_ready_i,
  input logic [LINE_W-1:0] txn_line_o,
  input logic [SECTS-1:0]  txn_sect_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  done_txns_o,
  input logic [CNT_W-1:0]  done_sects_o
);
  logic [LINE_W-1:0] last_q;
  logic              have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      have_q <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      have_q <= 1'b0;
    end else if (txn_valid_o && txn_ready_i) begin
      last_q <= txn_line_o;
      have_q <= 1'b1;
    end
  end

  p_busy_blocks_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> !req_ready_o);

  p_done_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  p_sect_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> txn_sect_o != '0);

  p_ascending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_o && have_q) |-> txn_line_o > last_q);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_o && !txn_ready_i) |=>
      (txn_valid_o && $stable(txn_line_o) && $stable(txn_sect_o)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_bounds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(done_sects_o) >= int'(done_txns_o) &&
                int'(done_sects_o) <= int'(SECTS) * int'(done_txns_o)));
endmodule

bind coal_warp coal_warp_chk #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/coal_warp_tb.sv
`timescale 1ns/1ps
module coal_warp_tb;
  localparam int LANES  = 32;
  localparam int ADDR_W = 32;
  localparam int LINE_W = ADDR_W - 7;
  localparam int CNT_W  = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic                    req_valid_i = 1'b0;
  logic                    req_ready_o;
  logic [LANES*ADDR_W-1:0] req_addr_i = '0;
  logic [LANES-1:0]        req_mask_i = '0;
  logic                    txn_valid_o;
  logic                    txn_ready_i = 1'b0;
  logic [LINE_W-1:0]       txn_line_o;
  logic [3:0]              txn_sect_o;
  logic                    rsp_valid_i = 1'b0;
  logic [LINE_W-1:0]       rsp_line_i = '0;
  logic [1023:0]           rsp_data_i = '0;
  logic [LANES*32-1:0]     lane_data_o;
  logic                    done_o;
  logic [CNT_W-1:0]        done_txns_o, done_sects_o;
  logic [7:0]              done_eff_o;

  coal_warp #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_mask_i(req_mask_i),
    .txn_valid_o(txn_valid_o), .txn_ready_i(txn_ready_i),
    .txn_line_o(txn_line_o), .txn_sect_o(txn_sect_o),
    .rsp_valid_i(rsp_valid_i), .rsp_line_i(rsp_line_i), .rsp_data_i(rsp_data_i),
    .lane_data_o(lane_data_o),
    .done_o(done_o), .done_txns_o(done_txns_o), .done_sects_o(done_sects_o),
    .done_eff_o(done_eff_o)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] s_addr [LANES];
  logic [LANES-1:0] s_mask;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'hC0DE_0000;
  endfunction

  // mode: 0 always ready, 1 ready on odd cycles, 2 ready every third cycle
  task automatic run_req(input string name, input int mode);
    logic [LINE_W-1:0] e_line [LANES];
    logic [3:0]        e_sect [LANES];
    int n = 0, s_tot = 0, a_tot = 0, idx = 0, e_eff;
    bit pend = 0, done_seen = 0, got_done = 0, stall = 0, order_ok = 1, hold_ok = 1;
    logic [LINE_W-1:0] pline = '0, st_line = '0;
    logic [3:0] st_sect = '0;
    int bad_lane = -1;
    // expected sorted line list
    for (int i = 0; i < LANES; i++) begin
      if (s_mask[i]) begin
        logic [LINE_W-1:0] l = s_addr[i][31:7];
        int k = 0;
        bit found = 0;
        a_tot++;
        for (int j = 0; j < n; j++) if (e_line[j] == l) begin
          e_sect[j][s_addr[i][6:5]] = 1'b1; found = 1;
        end
        if (!found) begin
          while (k < n && e_line[k] < l) k++;
          for (int j = n; j > k; j--) begin e_line[j] = e_line[j-1]; e_sect[j] = e_sect[j-1]; end
          e_line[k] = l; e_sect[k] = 4'b0; e_sect[k][s_addr[i][6:5]] = 1'b1; n++;
        end
      end
    end
    for (int j = 0; j < n; j++) s_tot += $countones(e_sect[j]);
    e_eff = (s_tot == 0) ? 0 : ((100 * a_tot) / (8 * s_tot) > 100 ? 100 : (100 * a_tot) / (8 * s_tot));

    @(negedge clk);
    for (int i = 0; i < LANES; i++) req_addr_i[i*32 +: 32] = s_addr[i];
    req_mask_i  = s_mask;
    req_valid_i = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid_i = 1'b0;
    chk(!req_ready_o, "R2", {name, " ready low while busy"}, req_ready_o, 0);

    for (int cyc = 0; cyc < 400; cyc++) begin
      if (pend) begin
        rsp_valid_i = 1'b1; rsp_line_i = pline;
        for (int w = 0; w < 32; w++) rsp_data_i[w*32 +: 32] = mem_word({pline, 7'b0} + 32'(4*w));
        pend = 0;
      end else rsp_valid_i = 1'b0;
      if (done_seen) break;
      if (done_o) begin
        done_seen = 1; got_done = 1;
        chk(req_ready_o, "R2", {name, " ready with done"}, req_ready_o, 1);
        chk(int'(done_txns_o) == n, "R7", {name, " txn count"}, done_txns_o, n);
        chk(int'(done_sects_o) == s_tot, "R7", {name, " sector count"}, done_sects_o, s_tot);
        chk(int'(done_eff_o) == e_eff, "R8", {name, " efficiency"}, done_eff_o, e_eff);
      end
      if (txn_valid_o) begin
        if (stall && (txn_line_o != st_line || txn_sect_o != st_sect)) hold_ok = 0;
        if (idx >= n || txn_line_o != e_line[idx] || txn_sect_o != e_sect[idx]) begin
          if (order_ok)
            chk(0, "R3", {name, " txn line/sectors"}, {txn_line_o, txn_sect_o},
                idx < n ? {e_line[idx], e_sect[idx]} : -1);
          order_ok = 0;
        end
        txn_ready_i = (mode == 0) || (mode == 1 && cyc % 2 == 1) || (mode == 2 && cyc % 3 == 2);
        stall = !txn_ready_i; st_line = txn_line_o; st_sect = txn_sect_o;
        if (txn_ready_i) begin idx++; pend = 1; pline = txn_line_o; end
      end else begin
        if (stall) hold_ok = 0;
        txn_ready_i = 1'b0; stall = 0;
      end
      @(posedge clk); @(negedge clk);
    end
    txn_ready_i = 1'b0; rsp_valid_i = 1'b0;
    chk(order_ok && idx == n, "R4", {name, " ascending lines, each once"}, idx, n);
    if (mode != 0) chk(hold_ok, "R5", {name, " hold under stall"}, hold_ok, 1);
    chk(got_done, "R7", {name, " done pulse"}, got_done, 1);
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] ev = s_mask[i] ? mem_word({s_addr[i][31:2], 2'b00}) : 32'h0;
      if (bad_lane < 0 && lane_data_o[i*32 +: 32] != ev) bad_lane = i;
    end
    chk(bad_lane < 0, "R9", {name, " lane data routing"}, bad_lane, -1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready_o, "R1", "ready after reset", req_ready_o, 1);
    chk(!txn_valid_o, "R1", "no txn after reset", txn_valid_o, 0);
    chk(!done_o, "R1", "no done after reset", done_o, 0);
    chk(lane_data_o == '0, "R1", "lane data zero", lane_data_o != '0, 0);
  endtask

  task automatic t_coalesced();  // R10
    for (int i = 0; i < LANES; i++) s_addr[i] = 32'h0000_1000 + 32'(4*i);
    s_mask = '1;
    run_req("coalesced R10", 0);
  endtask

  task automatic t_stride2();
    for (int i = 0; i < LANES; i++) s_addr[i] = 32'h0002_0000 + 32'(8*i);
    s_mask = '1;
    run_req("stride2 R8", 0);
  endtask

  task automatic t_records();
    for (int i = 0; i < LANES; i++) s_addr[i] = 32'h0003_0000 + 32'(16*i);
    s_mask = '1;
    run_req("records16 R8", 2);
  endtask

  task automatic t_scatter();  // descending addresses, stalling memory
    for (int i = 0; i < LANES; i++) s_addr[i] = 32'h0040_0000 + 32'((31-i)*384) + 32'(4*(i%8));
    s_mask = '1;
    run_req("scatter R4", 1);
  endtask

  task automatic t_partial();  // R6
    for (int i = 0; i < LANES; i++) s_addr[i] = 32'h0005_0000 + 32'(64*i);
    s_mask = 32'h0000_00F0;
    run_req("partial mask R6", 1);
  endtask

  task automatic t_empty();  // R6
    for (int i = 0; i < LANES; i++) s_addr[i] = 32'h0006_0000 + 32'(4*i);
    s_mask = '0;
    run_req("empty mask R6", 0);
  endtask

  task automatic t_broadcast();  // R10 merge, R8 clamp
    for (int i = 0; i < LANES; i++) s_addr[i] = 32'h0007_0044;
    s_mask = '1;
    run_req("broadcast R10", 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_coalesced();
    t_stride2();
    t_records();
    t_scatter();
    t_partial();
    t_empty();
    t_broadcast();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule